// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

A per-core countdown timer with a small 32-bit register interface. Software programs a start value, a clock prescaler and an interrupt entry that holds an 8-bit vector, a mask bit and a mode bit. The counter then runs down at the input clock divided by a power of two. When it reaches zero it raises a one-cycle interrupt request carrying the programmed vector. In one-shot mode the counter then stops. In periodic mode it reloads and counts again.

A global software-enable bit, kept in its own control register, freezes the timer and blocks its interrupts while it is clear. A completion register turns a write of zero into a one-cycle completion strobe for the downstream interrupt logic.

Every access is a single 32-bit read or write at a 16-byte-aligned offset. The read port is combinational. Offsets: control 0x00, timer entry 0x10, start count 0x20, live count 0x30 (read-only), prescaler 0x40, completion 0x50 (write-only).

Top module: `local_irq_timer`

## Requirements
- R1: After reset, every register reads zero except the timer entry, which reads 0x0001_0000 (masked, one-shot, vector 0). `irq_valid` and `eoi_done` are low.
- R2: An aligned write to 0x20 loads both the start count and the live count, and restarts the prescaler. Writing 0 stops the timer with the live count at 0 and no further requests.
- R3: The prescaler code is {bit 3, bit 1, bit 0} of register 0x40, and the divisor is 2^((code+1) mod 8), so code 7 divides by 1. The live count drops by one every divisor cycles, and a start value N gives its first request N·divisor cycles after the write.
- R4: With entry bit 17 = 0 (one-shot), exactly one request is made, and the live count stays at 0 afterwards.
- R5: With entry bit 17 = 1 (periodic), the counter reloads from the start count on the tick after reaching 0, so successive requests are (N+1)·divisor cycles apart.
- R6: With entry bit 16 = 1 (mask), no request is issued, but counting still runs to 0.
- R7: With control bit 8 = 0 (software enable off), the live count and the prescaler hold and no request is issued. Setting the bit resumes counting from the held value.
- R8: A request is a single-cycle `irq_valid` pulse, and `irq_vector` equals entry bits 7:0 during that pulse.
- R9: A write of 0 to 0x50 produces a one-cycle `eoi_done` pulse in the following cycle. A non-zero write there produces none.
- R10: A write whose address has any of bits 3:0 set changes no register, and a read at such an address returns 0.
- R11: Readback returns the control register as bits 8 and 7:0, the timer entry as bits 17, 16 and 7:0, the prescaler as bits 3, 1 and 0 only, and the start and live counts separately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read enable for the combinational read port |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; zero when not reading |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector carried by the request |
| eoi_done | output | 1 | One-cycle completion strobe |

## Verification
The embedded assertions check, on every cycle, the rules that hold at any moment:
- a request lasts one cycle and leaves the live count at zero;
- no request appears unless the timer was enabled and unmasked;
- a stopped one-shot counter stays at zero;
- a disabled counter holds its value;
- the live count never exceeds the start count;
- the completion strobe follows only a zero write.

The exact cycle of the first request, the periodic interval for each prescaler code, the live count midway through a countdown, and the effect of misaligned accesses depend on stimulus history. Only the bench's directed and random scenarios can show those.

// File: rtl/local_irq_timer.sv
module local_irq_timer #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_valid,
  output logic [7:0]        irq_vector,
  output logic              eoi_done
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_ENTRY = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_START = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] A_LIVE  = ADDR_W'('h30);
  localparam logic [ADDR_W-1:0] A_PRE   = ADDR_W'('h40);
  localparam logic [ADDR_W-1:0] A_DONE  = ADDR_W'('h50);

  logic [7:0]       spur_vec, vec;
  logic             sw_en, masked, periodic;
  logic [2:0]       pre_code;
  logic [CNT_W-1:0] start_cnt, live_cnt;
  logic [6:0]       pre_cnt;

  wire aligned  = (bus_addr[3:0] == 4'd0);
  wire wr_ok    = bus_wr && aligned;
  wire wr_start = wr_ok && (bus_addr == A_START);
  wire wr_done  = wr_ok && (bus_addr == A_DONE);

  wire [2:0] shift    = pre_code + 3'd1;
  wire [7:0] div_full = 8'd1 << shift;
  wire [6:0] div_mask = 7'(div_full - 8'd1);

  wire running = sw_en && ((live_cnt != '0) || (periodic && (start_cnt != '0)));
  wire tick    = running && (pre_cnt == div_mask);
  wire fire    = !wr_start && tick && (live_cnt == CNT_W'(1)) && !masked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spur_vec <= '0;
      sw_en    <= 1'b0;
      vec      <= '0;
      masked   <= 1'b1;
      periodic <= 1'b0;
      pre_code <= '0;
    end else if (wr_ok) begin
      case (bus_addr)
        A_CTRL: begin
          spur_vec <= bus_wdata[7:0];
          sw_en    <= bus_wdata[8];
        end
        A_ENTRY: begin
          vec      <= bus_wdata[7:0];
          masked   <= bus_wdata[16];
          periodic <= bus_wdata[17];
        end
        A_PRE:   pre_code <= {bus_wdata[3], bus_wdata[1:0]};
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_cnt <= '0;
      live_cnt  <= '0;
      pre_cnt   <= '0;
    end else if (wr_start) begin
      start_cnt <= CNT_W'(bus_wdata);
      live_cnt  <= CNT_W'(bus_wdata);
      pre_cnt   <= '0;
    end else if (running) begin
      pre_cnt <= tick ? 7'd0 : pre_cnt + 7'd1;
      if (tick) live_cnt <= (live_cnt != '0) ? live_cnt - CNT_W'(1) : start_cnt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_valid  <= 1'b0;
      irq_vector <= '0;
      eoi_done   <= 1'b0;
    end else begin
      irq_valid  <= fire;
      irq_vector <= fire ? vec : 8'd0;
      eoi_done   <= wr_done && (bus_wdata == 32'd0);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && aligned) begin
      case (bus_addr)
        A_CTRL:  bus_rdata = {23'd0, sw_en, spur_vec};
        A_ENTRY: bus_rdata = {14'd0, periodic, masked, 8'd0, vec};
        A_START: bus_rdata = 32'(start_cnt);
        A_LIVE:  bus_rdata = 32'(live_cnt);
        A_PRE:   bus_rdata = {28'd0, pre_code[2], 1'b0, pre_code[1:0]};
        default: bus_rdata = '0;
      endcase
    end
  end

  assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |=> !irq_valid);
  assert_irq_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (live_cnt == '0 || $past(wr_start)));
  assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> ($past(sw_en) && !$past(masked)));
  assert_oneshot_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!periodic && live_cnt == '0 && !wr_start) |=> live_cnt == '0);
  assert_disabled_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_en && !wr_start) |=> $stable(live_cnt));
  assert_live_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    live_cnt <= start_cnt);
  assert_eoi_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_done |-> ($past(bus_wr) && $past(bus_wdata) == 32'd0));
endmodule

// File: tb/test_local_irq_timer.sv
module test_local_irq_timer;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        irq_valid, eoi_done;
  logic [7:0]  irq_vector;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  local_irq_timer i_local_irq_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_valid(irq_valid), .irq_vector(irq_vector), .eoi_done(eoi_done));

  function automatic int divisor(input int code);
    return 1 << ((code + 1) % 8);
  endfunction
  function automatic logic [31:0] pre_word(input int code);
    return 32'(((code >> 2) & 1) << 3 | (code & 3));
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic run(input int cycles, output int first, output int second,
                     output int count, output logic [7:0] v);
    first = -1; second = -1; count = 0; v = '0;
    for (int c = 1; c <= cycles; c++) begin
      @(negedge clk);
      if (irq_valid) begin
        count++;
        if (first < 0) begin first = c; v = irq_vector; end
        else if (second < 0) second = c;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    logic [7:0] v;
    int f, s, n, N, code, D;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(12'h10, d); chk(d == 32'h0001_0000, "R1 entry", d, 32'h0001_0000);
    rd(12'h00, d); chk(d == 0, "R1 ctrl", d, 0);
    rd(12'h20, d); chk(d == 0, "R1 start", d, 0);
    rd(12'h30, d); chk(d == 0, "R1 live", d, 0);
    rd(12'h40, d); chk(d == 0, "R1 prescaler", d, 0);
    chk(!irq_valid && !eoi_done, "R1 outputs", {irq_valid, eoi_done}, 0);

    // R11 readback
    wr(12'h00, 32'hFFFF_FFFF); rd(12'h00, d); chk(d == 32'h1FF, "R11 ctrl", d, 32'h1FF);
    wr(12'h40, 32'hFFFF_FFFF); rd(12'h40, d); chk(d == 32'hB, "R11 prescaler", d, 32'hB);
    wr(12'h10, 32'hFFFF_FFFF); rd(12'h10, d); chk(d == 32'h300FF, "R11 entry", d, 32'h300FF);
    wr(12'h10, 32'h0001_0000);
    wr(12'h00, 32'h10F);

    // R3 R4 R8 one-shot, random start value and prescaler
    for (int i = 0; i < 8; i++) begin
      N = 1 + int'($urandom % 12);
      code = (i < 2) ? 7 - i * 7 : int'($urandom % 8);
      D = divisor(code);
      v = 8'($urandom);
      wr(12'h40, pre_word(code));
      rd(12'h40, d); chk(d == pre_word(code), "R11 prescaler code", d, pre_word(code));
      wr(12'h10, {24'd0, v});
      wr(12'h20, 32'(N));
      run(N * D + 2 * D + 4, f, s, n, d2[7:0]);
      chk(f == N * D, "R3 first request cycle", f, N * D);
      chk(n == 1, "R4 single request", n, 1);
      chk(d2[7:0] == v, "R8 vector", d2[7:0], v);
      rd(12'h30, d); chk(d == 0, "R4 live stays zero", d, 0);
      rd(12'h20, d); chk(d == 32'(N), "R11 start readback", d, N);
    end

    // R5 periodic interval
    for (int i = 0; i < 4; i++) begin
      N = 1 + int'($urandom % 6);
      code = int'($urandom % 8);
      D = divisor(code);
      wr(12'h40, pre_word(code));
      wr(12'h10, 32'h0002_0055);
      wr(12'h20, 32'(N));
      run(N * D + (N + 1) * D + 1, f, s, n, v);
      chk(f == N * D, "R5 first request", f, N * D);
      chk(s - f == (N + 1) * D, "R5 interval", s - f, (N + 1) * D);
      // R2 stop by writing zero
      wr(12'h20, 32'd0);
      run(3 * D * (N + 1), f, s, n, v);
      chk(n == 0, "R2 stopped no request", n, 0);
      rd(12'h30, d); chk(d == 0, "R2 stopped live", d, 0);
    end

    // R3 live count mid countdown (code 0 -> divide by 2)
    wr(12'h10, 32'h0000_0011);
    wr(12'h40, 32'd0);
    wr(12'h20, 32'd10);
    repeat (5) @(negedge clk);
    rd(12'h30, d); chk(d == 8, "R3 live midway", d, 8);
    rd(12'h20, d); chk(d == 10, "R2 start loaded", d, 10);
    wr(12'h20, 32'd0);

    // R6 mask
    wr(12'h40, 32'hB);
    wr(12'h10, 32'h0001_0022);
    wr(12'h20, 32'd3);
    run(10, f, s, n, v);
    chk(n == 0, "R6 masked no request", n, 0);
    rd(12'h30, d); chk(d == 0, "R6 counted to zero", d, 0);

    // R7 software enable
    wr(12'h10, 32'h0000_0033);
    wr(12'h00, 32'h0);
    wr(12'h20, 32'd5);
    run(10, f, s, n, v);
    chk(n == 0, "R7 disabled no request", n, 0);
    rd(12'h30, d); chk(d == 5, "R7 count frozen", d, 5);
    wr(12'h00, 32'h100);
    run(8, f, s, n, v);
    chk(f == 5 && n == 1, "R7 resumes", f, 5);

    // R9 completion
    wr(12'h50, 32'd0);
    chk(eoi_done == 1'b1, "R9 zero write strobe", eoi_done, 1);
    @(negedge clk); chk(eoi_done == 1'b0, "R9 strobe one cycle", eoi_done, 0);
    wr(12'h50, 32'd7);
    chk(eoi_done == 1'b0, "R9 nonzero ignored", eoi_done, 0);

    // R10 misaligned
    wr(12'h20, 32'd0);
    wr(12'h24, 32'd99);
    rd(12'h20, d); chk(d == 0, "R10 misaligned write ignored", d, 0);
    rd(12'h30, d); chk(d == 0, "R10 no start from misaligned", d, 0);
    wr(12'h04, 32'h0);
    rd(12'h00, d); chk(d == 32'h100, "R10 ctrl untouched", d, 32'h100);
    rd(12'h14, d); chk(d == 0, "R10 misaligned read zero", d, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule